// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End with Chip Erase

This block is the command front end of a parallel NOR flash model. It watches host bus writes, each an address and a data word, and decodes the keyed sequence that starts a whole-array erase. The first two writes of that sequence also lead to an identification mode. A separate single write enters a query mode. The array is a small register memory.

After the sixth write of the erase sequence, an internal engine runs with no help from the host. It first writes zero to every word of the array, which is the preprogram step, and waits out a preprogram window. It then runs an erase window and finally sets every word to all ones. The length of each window is a parameter given in clock cycles. While the engine runs, reads return a status word instead of array data and the ready output is low. Any write on the bus in that time is dropped.

The host polls either the ready output or the toggling status bits to see when the erase is done. Pulling the asynchronous reset low stops the erase at once and returns the block to array reads.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The six writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555, given in that order, start an erase. Only the low byte of data and the low 11 address bits are compared. `ready_o` is low from the clock edge that samples the sixth write.
- R2: A write that does not match the next expected step sends the decoder back to read mode, and no erase starts.
- R3: An erase keeps `ready_o` low for exactly PREPROG_CYC + ERASE_CYC cycles. After it ends, every array word reads 0xFFFF.
- R4: A read while busy returns a status word with bit 7 = 0. Every bit other than bits 6 and 2 is also 0.
- R5: On each successive read while busy, bits 6 and 2 invert, and the two bits are always equal.
- R6: Writes while busy are dropped. A complete erase sequence written during an erase does not start a second erase.
- R7: The identification mode and the query mode cannot be entered while busy. After the erase, words 0x000, 0x001 and 0x010 read 0xFFFF.
- R8: While `rst_ni` is low, `ready_o` is high, with no clock edge needed, and `rdata_o` is 0. Reset ends a running erase, and reads after reset are no longer status reads.
- R9: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 enter identification mode. Address bits [1:0] = 0 read MFR_ID, 1 reads DEV_ID, and other values read 0. Any write leaves this mode.
- R10: The write 0x98@0x055 from read mode enters query mode. Addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059, and other addresses read 0. Any write leaves this mode.
- R11: `rdata_o` takes the read value at the edge that samples `rd_en_i` and holds it in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data or command byte |
| rdata_o | output | 16 | Registered read data, status word while busy |
| ready_o | output | 1 | High when idle, low while an erase runs |

## Verification
A write or read is applied for one clock. Its effect is sampled at the falling edge that follows the rising edge which captured it: `ready_o` has dropped by then after the sixth erase write, and `rdata_o` holds the value for that read. The erase length is measured by counting falling edges with `ready_o` low, starting right after the sixth write, and the count must equal PREPROG_CYC + ERASE_CYC. For the reset abort, the ready output is checked a fraction of a cycle after reset falls, with no clock edge in between.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UL1, ST_UL2, ST_SETUP, ST_UL3, ST_UL4, ST_IDENT, ST_QUERY
  } mode_e;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_ERS} phase_e;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [10:0] QRY_ADDR   = 11'h055;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_SETUP  = 8'h80;
  localparam logic [7:0]  CMD_CHIPER = 8'h10;
  localparam logic [7:0]  CMD_IDENT  = 8'h90;
  localparam logic [7:0]  CMD_QUERY  = 8'h98;
endpackage

// File: rtl/flash_seq_dec.sv
`timescale 1ns/1ps
module flash_seq_dec
  import flash_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              busy_i,
  output mode_e             mode_o,
  output logic              start_o
);
  mode_e mode_q, mode_d;

  function automatic logic hit(input logic [10:0] a, input logic [7:0] d);
    return (addr_i[10:0] == a) && (wdata_i[7:0] == d);
  endfunction

  always_comb begin
    mode_d  = mode_q;
    start_o = 1'b0;
    if (wr_en_i && !busy_i) begin
      unique case (mode_q)
        ST_READ:  mode_d = hit(KEY_ADDR_A, KEY_DATA_A) ? ST_UL1 :
                           hit(QRY_ADDR, CMD_QUERY)    ? ST_QUERY : ST_READ;
        ST_UL1:   mode_d = hit(KEY_ADDR_B, KEY_DATA_B) ? ST_UL2 : ST_READ;
        ST_UL2:   mode_d = hit(KEY_ADDR_A, CMD_SETUP)  ? ST_SETUP :
                           hit(KEY_ADDR_A, CMD_IDENT)  ? ST_IDENT : ST_READ;
        ST_SETUP: mode_d = hit(KEY_ADDR_A, KEY_DATA_A) ? ST_UL3 : ST_READ;
        ST_UL3:   mode_d = hit(KEY_ADDR_B, KEY_DATA_B) ? ST_UL4 : ST_READ;
        ST_UL4: begin
          start_o = hit(KEY_ADDR_A, CMD_CHIPER);
          mode_d  = ST_READ;
        end
        default:  mode_d = ST_READ; // ident/query: any write exits
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= ST_READ;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/flash_erase_eng.sv
`timescale 1ns/1ps
module flash_erase_eng
  import flash_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int PREPROG_CYC = 24,
  parameter int ERASE_CYC   = 40,
  parameter int IDX_W       = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             busy_o,
  output logic [15:0]      rd_word_o
);
  localparam int LIM   = (PREPROG_CYC > ERASE_CYC) ? PREPROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(LIM + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_pre, last_ers, zero_wr, fill_wr;
  logic [15:0]      mem_q [DEPTH];

  assign last_pre = (cnt_q == CNT_W'(PREPROG_CYC - 1));
  assign last_ers = (cnt_q == CNT_W'(ERASE_CYC - 1));
  // preprogram walks one word per cycle; PREPROG_CYC must cover DEPTH
  assign zero_wr  = (phase_q == PH_PRE) && (cnt_q < CNT_W'(DEPTH));
  assign fill_wr  = (phase_q == PH_ERS) && last_ers;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_PRE;
          cnt_q   <= '0;
        end
        PH_PRE: if (last_pre) begin
          phase_q <= PH_ERS;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_ERS: if (last_ers) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (fill_wr) mem_q[i] <= '1;
      else if (zero_wr && cnt_q == CNT_W'(i)) mem_q[i] <= '0;
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/flash_rd_mux.sv
`timescale 1ns/1ps
module flash_rd_mux
  import flash_pkg::*;
#(
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h227E
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic        busy_i,
  input  mode_e       mode_i,
  input  logic [7:0]  addr_lo_i,
  input  logic [15:0] arr_word_i,
  output logic [15:0] rdata_o
);
  logic        tog6_q, tog2_q;
  logic [15:0] rd_val;

  always_comb begin
    rd_val = arr_word_i;
    if (busy_i) begin
      rd_val    = '0;  // bit 7 reads 0 until done
      rd_val[6] = tog6_q;
      rd_val[2] = tog2_q;
    end else if (mode_i == ST_IDENT) begin
      unique case (addr_lo_i[1:0])
        2'd0:    rd_val = MFR_ID;
        2'd1:    rd_val = DEV_ID;
        default: rd_val = '0;
      endcase
    end else if (mode_i == ST_QUERY) begin
      unique case (addr_lo_i)
        8'h10:   rd_val = 16'h0051;
        8'h11:   rd_val = 16'h0052;
        8'h12:   rd_val = 16'h0059;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      tog6_q  <= 1'b0;
      tog2_q  <= 1'b0;
    end else if (rd_en_i) begin
      rdata_o <= rd_val;
      if (busy_i) begin
        tog6_q <= ~tog6_q;
        tog2_q <= ~tog2_q;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DEPTH       = 16,
  parameter int          PREPROG_CYC = 24,
  parameter int          ERASE_CYC   = 40,
  parameter logic [15:0] MFR_ID      = 16'h0001,
  parameter logic [15:0] DEV_ID      = 16'h227E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              ready_o
);
  localparam int IDX_W = $clog2(DEPTH);

  mode_e       mode;
  logic        start, busy;
  logic [15:0] arr_word;

  flash_seq_dec #(.ADDR_W(ADDR_W)) i_dec (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .busy_i(busy), .mode_o(mode), .start_o(start)
  );

  flash_erase_eng #(
    .DEPTH(DEPTH), .PREPROG_CYC(PREPROG_CYC), .ERASE_CYC(ERASE_CYC), .IDX_W(IDX_W)
  ) i_eng (
    .clk_i, .rst_ni, .start_i(start), .rd_idx_i(addr_i[IDX_W-1:0]),
    .busy_o(busy), .rd_word_o(arr_word)
  );

  flash_rd_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_rd (
    .clk_i, .rst_ni, .rd_en_i, .busy_i(busy), .mode_i(mode),
    .addr_lo_i(addr_i[7:0]), .arr_word_i(arr_word), .rdata_o
  );

  assign ready_o = !busy;
endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk
  import flash_pkg::*;
#(
  parameter int PREPROG_CYC = 24,
  parameter int ERASE_CYC   = 40
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_en_i,
  input logic        start_i,
  input logic        busy_i,
  input mode_e       mode_i,
  input logic [15:0] rdata_i,
  input logic        ready_i
);
  int busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_i) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R1
  erase_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_i);
  // R3
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> busy_cnt < PREPROG_CYC + ERASE_CYC);
  // R3
  erase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt == PREPROG_CYC + ERASE_CYC);
  // R4
  status_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i) |=> (rdata_i & 16'hFFBB) == 16'h0000);
  // R5
  toggle_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i) |=> rdata_i[6] == rdata_i[2]);
  // R5
  toggle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_i && $past(rd_en_i && busy_i)) |=> rdata_i[6] != $past(rdata_i[6]));
  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_i);
  // R7
  busy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> mode_i == ST_READ);
  // R8
  reset_ready_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (ready_i && rdata_i == 16'h0000));
  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_i));
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(
  .PREPROG_CYC(PREPROG_CYC), .ERASE_CYC(ERASE_CYC)
) i_flash_cmd_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .start_i(start),
  .busy_i(busy), .mode_i(mode), .rdata_i(rdata_o), .ready_i(ready_o)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int PRE = 24;
  localparam int ERS = 40;
  localparam int DEP = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ready_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  flash_cmd_ctrl #(
    .ADDR_W(12), .DEPTH(DEP), .PREPROG_CYC(PRE), .ERASE_CYC(ERS),
    .MFR_ID(16'h0001), .DEV_ID(16'h227E)
  ) i_flash_cmd_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o, .ready_o
  );

  // op: 0 write, 1 read and compare, 2 compare ready_o
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [15:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'h555, 16'h00AA, 4'd9},  // R9 entry
    '{2'd0, 12'h2AA, 16'h0055, 4'd9},
    '{2'd0, 12'h555, 16'h0090, 4'd9},
    '{2'd1, 12'h000, 16'h0001, 4'd9},  // R9 maker id
    '{2'd1, 12'h001, 16'h227E, 4'd9},  // R9 device id
    '{2'd1, 12'h002, 16'h0000, 4'd9},
    '{2'd1, 12'h004, 16'h0001, 4'd9},
    '{2'd0, 12'h000, 16'h1234, 4'd9},  // R9 any write exits
    '{2'd0, 12'h055, 16'h0098, 4'd10}, // R10 entry only from read mode
    '{2'd1, 12'h010, 16'h0051, 4'd10},
    '{2'd1, 12'h011, 16'h0052, 4'd10},
    '{2'd1, 12'h012, 16'h0059, 4'd10},
    '{2'd1, 12'h013, 16'h0000, 4'd10},
    '{2'd0, 12'h000, 16'h00F0, 4'd10}, // R10 exit
    '{2'd0, 12'h555, 16'h00AA, 4'd2},  // R2 broken at step five
    '{2'd0, 12'h2AA, 16'h0055, 4'd2},
    '{2'd0, 12'h555, 16'h0080, 4'd2},
    '{2'd0, 12'h555, 16'h00AA, 4'd2},
    '{2'd0, 12'h2AA, 16'h0000, 4'd2},
    '{2'd0, 12'h555, 16'h0010, 4'd2},
    '{2'd2, 12'h000, 16'h0001, 4'd2},  // R2 no erase
    '{2'd0, 12'h555, 16'h00AA, 4'd2},  // R2 decoder back in read mode
    '{2'd0, 12'h2AA, 16'h0055, 4'd2},
    '{2'd0, 12'h555, 16'h0090, 4'd2},
    '{2'd1, 12'h000, 16'h0001, 4'd2},
    '{2'd0, 12'h000, 16'h00F0, 4'd2}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [15:0] v, output logic was_busy);
    @(negedge clk_i);
    was_busy = !ready_o;
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic erase_seq();
    do_wr(12'h555, 16'h00AA);
    do_wr(12'h2AA, 16'h0055);
    do_wr(12'h555, 16'h0080);
    do_wr(12'h555, 16'h00AA);
    do_wr(12'h2AA, 16'h0055);
    do_wr(12'h555, 16'h0010);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, prev;
    logic        b, have_prev;
    int          cnt;

    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8 reset ready", {15'd0, ready_o}, 16'd1);
    chk("R8 reset rdata", rdata_o, 16'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      unique case (VECS[i].op)
        2'd0: do_wr(VECS[i].addr, VECS[i].val);
        2'd1: begin
          do_rd(VECS[i].addr, v, b);
          chk($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].val);
        end
        default: begin
          @(negedge clk_i);
          chk($sformatf("R%0d vec %0d ready", VECS[i].req, i), {15'd0, ready_o}, VECS[i].val);
        end
      endcase
    end

    // R11 output holds while no read is issued
    do_wr(12'h055, 16'h0098);
    do_rd(12'h011, v, b);
    addr_i = 12'h012;
    repeat (3) @(negedge clk_i);
    chk("R11 hold", rdata_o, 16'h0052);
    do_wr(12'h000, 16'h00F0);

    // R1 start, R4/R5 status polling, R6/R7 writes during busy
    erase_seq();
    chk("R1 ready low", {15'd0, ready_o}, 16'd0);
    have_prev = 1'b0;
    for (int k = 0; k < 4; k++) begin
      do_rd(12'h000, v, b);
      if (b) begin
        chk("R4 status mask", v & 16'hFFBB, 16'h0000);
        chk("R5 pair equal", {15'd0, v[6]}, {15'd0, v[2]});
        if (have_prev) chk("R5 toggle", {14'd0, v[6], v[2]}, {14'd0, ~prev[6], ~prev[2]});
        prev = v; have_prev = 1'b1;
      end
    end
    do_wr(12'h555, 16'h00AA);  // R7 ident attempt
    do_wr(12'h2AA, 16'h0055);
    do_wr(12'h555, 16'h0090);
    do_wr(12'h055, 16'h0098);  // R7 query attempt
    erase_seq();               // R6 second erase attempt
    have_prev = 1'b0;
    while (!ready_o) begin
      do_rd(12'h000, v, b);
      if (b) begin
        chk("R4 status bit7", {15'd0, v[7]}, 16'd0);
        if (have_prev) chk("R5 toggle", {14'd0, v[6], v[2]}, {14'd0, ~prev[6], ~prev[2]});
        prev = v; have_prev = 1'b1;
      end else have_prev = 1'b0;
    end
    repeat (4) @(negedge clk_i);
    chk("R6 no second erase", {15'd0, ready_o}, 16'd1);
    for (int a = 0; a < DEP; a++) begin
      do_rd(12'(a), v, b);
      chk("R3 array ones", v, 16'hFFFF);
    end
    do_rd(12'h000, v, b); chk("R7 no ident word0", v, 16'hFFFF);
    do_rd(12'h001, v, b); chk("R7 no ident word1", v, 16'hFFFF);
    do_rd(12'h010, v, b); chk("R7 no query", v, 16'hFFFF);

    // R3 exact duration
    erase_seq();
    cnt = 0;
    while (!ready_o) begin
      @(negedge clk_i);
      cnt++;
    end
    chk("R3 busy cycles", 16'(cnt), 16'(PRE + ERS));

    // R8 abort by reset mid-erase
    erase_seq();
    repeat (10) @(negedge clk_i);
    chk("R8 busy before abort", {15'd0, ready_o}, 16'd0);
    rst_ni = 1'b0;
    #1;
    chk("R8 abort ready", {15'd0, ready_o}, 16'd1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    do_rd(12'h003, prev, b);
    do_rd(12'h003, v, b);
    chk("R8 array read stable", v, prev);
    do_wr(12'h555, 16'h00AA);
    do_wr(12'h2AA, 16'h0055);
    do_wr(12'h555, 16'h0090);
    do_rd(12'h001, v, b);
    chk("R8 read mode resumed", v, 16'h227E);
    do_wr(12'h000, 16'h00F0);

    finish_run();
  end
endmodule